// File: doc/BRIEF.md
# Direct-Mapped Write-Back Line Cache

This block places a small direct-mapped cache between a narrow request/acknowledge subordinate bus and a wide memory port. Each cache line is exactly one memory word, packed from several bus words. Bus reads are served from the line store. Bus writes merge only the byte lanes whose select bit is set into the stored line, and they mark the line dirty. The memory is not touched again until that line is evicted.

On a miss the controller first checks the victim line. If the victim is valid and dirty, it writes the victim back with one write command followed by one write-data transfer. It then fetches the requested line with one read command followed by one read-data transfer. The request is then replayed against the refilled line, and the bus cycle is acknowledged. Only one memory operation is outstanding at any time. The geometry is set by parameters: the number of lines is the capacity in lanes times the lane width, divided by the memory width. Parameter sets that are not powers of two, or where the memory width is not at least twice the bus width, stop elaboration.

Top module: `wb_cache`

## Requirements
- R1: After reset no line is valid: `bus_ack` and all memory valid/ready outputs are low, and the first access to any line, even one whose tag bits are zero, issues a memory read.
- R2: The bus word address splits, from bit 0 upward, into a word offset (log2 of memory width over bus width), a line index, and a tag. The memory address of a line is {tag, index}, i.e. the bus address with the offset bits removed.
- R3: A miss on an invalid or clean line issues exactly one command with `mem_cmd_we` low, followed by one read-data transfer. The bus then receives bus word k of the fetched memory word, bits [k*BUS_DW +: BUS_DW], where k is the word offset.
- R4: A hit, read or write, completes with no memory command.
- R5: A bus write changes only the GRAN-bit lanes whose `bus_sel` bit is set (bit i covers data bits [i*GRAN +: GRAN]). All other lanes of the word and of the line keep their values.
- R6: A miss on a valid dirty line first issues a command with `mem_cmd_we` high at the victim's address, carrying the latest line contents on one write-data transfer. Only then is the read of the new line issued.
- R7: A miss on a valid clean line issues no write-back.
- R8: At most one of `mem_cmd_valid`, `mem_wr_valid`, `mem_rd_ready` is high in any cycle. Command address and write-enable, and write data, stay stable while valid is high and ready is low.
- R9: `bus_ack` is a one-cycle pulse given only after the access has been applied to a resident line. A read returns the most recently written value of that word, whether it was last written while cached or was restored from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cyc | input | 1 | Bus cycle active |
| bus_stb | input | 1 | Bus request strobe |
| bus_we | input | 1 | Bus write (1) or read (0) |
| bus_adr | input | ADDR_W | Bus word address |
| bus_sel | input | BUS_DW/GRAN | Byte-lane write select |
| bus_dat_w | input | BUS_DW | Bus write data |
| bus_dat_r | output | BUS_DW | Bus read data, valid with ack |
| bus_ack | output | 1 | One-cycle acknowledge |
| mem_cmd_valid | output | 1 | Memory command valid |
| mem_cmd_ready | input | 1 | Memory command accepted |
| mem_cmd_addr | output | ADDR_W-log2(MEM_DW/BUS_DW) | Memory line address |
| mem_cmd_we | output | 1 | Command is a write |
| mem_wr_valid | output | 1 | Write data valid |
| mem_wr_ready | input | 1 | Write data accepted |
| mem_wr_data | output | MEM_DW | Write-back line |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_ready | output | 1 | Cache waits for read data |
| mem_rd_data | input | MEM_DW | Fetched line |

## Verification
The assertions assume that the bus master holds the cycle, strobe, address, select and write data steady from the start of a request until it sees the acknowledge. They also assume that the memory raises read-data valid only while the cache signals read-ready. The bench meets both assumptions. Its bus task changes the request only on falling edges after the acknowledge. Its memory responder answers each phase only after it has seen that phase's valid or ready, with a varying delay of zero to two cycles, so stall cycles on every stream are covered.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOOK   = 3'd1,
    ST_WB_CMD = 3'd2,
    ST_WB_DAT = 3'd3,
    ST_RD_CMD = 3'd4,
    ST_RD_DAT = 3'd5
  } wbc_state_e;

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction
endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
  parameter int LINES = 4,
  parameter int IDX_W = 2,
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             fill,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             mark_dirty,
  output logic             valid_o,
  output logic             dirty_o,
  output logic [TAG_W-1:0] tag_o
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_mem [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end else if (mark_dirty) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) tag_mem[idx] <= fill_tag;
  end

  assign valid_o = valid_q[idx];
  assign dirty_o = dirty_q[idx];
  assign tag_o   = tag_mem[idx];
endmodule

// File: rtl/wbc_line_ram.sv
module wbc_line_ram #(
  parameter int LINES = 4,
  parameter int IDX_W = 2,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] addr,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [LINES];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
  import wbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       req_we,
  input  logic       hit,
  input  logic       evict,
  input  logic       cmd_ready,
  input  logic       wr_ready,
  input  logic       rd_valid,
  output wbc_state_e state_o,
  output logic       ack_o,
  output logic       line_wr,
  output logic       fill,
  output logic       mark_dirty
);
  wbc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req && !ack_o) state_d = ST_LOOK;
      ST_LOOK:   if (hit) state_d = ST_IDLE;
                 else if (evict) state_d = ST_WB_CMD;
                 else state_d = ST_RD_CMD;
      ST_WB_CMD: if (cmd_ready) state_d = ST_WB_DAT;
      ST_WB_DAT: if (wr_ready) state_d = ST_RD_CMD;
      ST_RD_CMD: if (cmd_ready) state_d = ST_RD_DAT;
      ST_RD_DAT: if (rd_valid) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ack_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_o   <= (state_q == ST_LOOK) && hit;
    end
  end

  assign state_o    = state_q;
  assign line_wr    = (state_q == ST_LOOK) && hit && req_we;
  assign mark_dirty = line_wr;
  assign fill       = (state_q == ST_RD_DAT) && rd_valid;
endmodule

// File: rtl/wb_cache.sv
module wb_cache
  import wbc_pkg::*;
#(
  parameter int BUS_DW      = 16,
  parameter int GRAN        = 8,
  parameter int MEM_DW      = 32,
  parameter int CACHE_UNITS = 16,
  parameter int ADDR_W      = 8,
  localparam int RATIO   = MEM_DW / BUS_DW,
  localparam int OFF_W   = $clog2(RATIO),
  localparam int LINES   = (CACHE_UNITS * GRAN) / MEM_DW,
  localparam int IDX_W   = $clog2(LINES),
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W,
  localparam int MADDR_W = ADDR_W - OFF_W,
  localparam int SEL_W   = BUS_DW / GRAN
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_cyc,
  input  logic               bus_stb,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_adr,
  input  logic [SEL_W-1:0]   bus_sel,
  input  logic [BUS_DW-1:0]  bus_dat_w,
  output logic [BUS_DW-1:0]  bus_dat_r,
  output logic               bus_ack,
  output logic               mem_cmd_valid,
  input  logic               mem_cmd_ready,
  output logic [MADDR_W-1:0] mem_cmd_addr,
  output logic               mem_cmd_we,
  output logic               mem_wr_valid,
  input  logic               mem_wr_ready,
  output logic [MEM_DW-1:0]  mem_wr_data,
  input  logic               mem_rd_valid,
  output logic               mem_rd_ready,
  input  logic [MEM_DW-1:0]  mem_rd_data
);
  if (!is_pow2(CACHE_UNITS) || !is_pow2(BUS_DW) || !is_pow2(GRAN) ||
      (MEM_DW % BUS_DW) != 0 || !is_pow2(RATIO) || RATIO < 2 ||
      LINES < 2 || (BUS_DW % GRAN) != 0 || TAG_W < 1) begin : g_bad_cfg
    $fatal(1, "wb_cache: unsupported geometry parameters");
  end

  wbc_state_e          state;
  logic                line_wr, fill, mark_dirty;
  logic                tag_valid, tag_dirty, hit, evict;
  logic [TAG_W-1:0]    tag_rd;
  logic [MEM_DW-1:0]   line_q, line_merged, ram_wdata;
  logic [BUS_DW-1:0]   line_words [RATIO];

  logic [OFF_W-1:0] req_off;
  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  assign req_off = bus_adr[OFF_W-1:0];
  assign req_idx = bus_adr[OFF_W +: IDX_W];
  assign req_tag = bus_adr[ADDR_W-1 -: TAG_W];

  assign hit   = tag_valid && (tag_rd == req_tag);
  assign evict = tag_valid && tag_dirty && !hit;

  wbc_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req        (bus_cyc && bus_stb),
    .req_we     (bus_we),
    .hit        (hit),
    .evict      (evict),
    .cmd_ready  (mem_cmd_ready),
    .wr_ready   (mem_wr_ready),
    .rd_valid   (mem_rd_valid),
    .state_o    (state),
    .ack_o      (bus_ack),
    .line_wr    (line_wr),
    .fill       (fill),
    .mark_dirty (mark_dirty)
  );

  wbc_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk        (clk),
    .rst        (rst),
    .idx        (req_idx),
    .fill       (fill),
    .fill_tag   (req_tag),
    .mark_dirty (mark_dirty),
    .valid_o    (tag_valid),
    .dirty_o    (tag_dirty),
    .tag_o      (tag_rd)
  );

  wbc_line_ram #(.LINES(LINES), .IDX_W(IDX_W), .WIDTH(MEM_DW)) u_ram (
    .clk   (clk),
    .addr  (req_idx),
    .we    (line_wr || fill),
    .wdata (ram_wdata),
    .rdata (line_q)
  );

  for (genvar w = 0; w < RATIO; w++) begin : g_word
    assign line_words[w] = line_q[w*BUS_DW +: BUS_DW];
    for (genvar b = 0; b < SEL_W; b++) begin : g_lane
      assign line_merged[w*BUS_DW + b*GRAN +: GRAN] =
        (req_off == OFF_W'(w) && bus_sel[b]) ? bus_dat_w[b*GRAN +: GRAN]
                                             : line_q[w*BUS_DW + b*GRAN +: GRAN];
    end
  end

  assign ram_wdata = fill ? mem_rd_data : line_merged;

  always_ff @(posedge clk) begin
    if (state == ST_LOOK && hit && !bus_we) bus_dat_r <= line_words[req_off];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_cmd_addr <= '0;
      mem_cmd_we   <= 1'b0;
    end else if (state == ST_LOOK && !hit) begin
      mem_cmd_addr <= evict ? {tag_rd, req_idx} : {req_tag, req_idx};
      mem_cmd_we   <= evict;
    end else if (state == ST_WB_DAT && mem_wr_ready) begin
      mem_cmd_addr <= {req_tag, req_idx};
      mem_cmd_we   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (state == ST_LOOK && evict) mem_wr_data <= line_q;
  end

  assign mem_cmd_valid = (state == ST_WB_CMD) || (state == ST_RD_CMD);
  assign mem_wr_valid  = (state == ST_WB_DAT);
  assign mem_rd_ready  = (state == ST_RD_DAT);
endmodule

// File: rtl/wb_cache_chk.sv
module wb_cache_chk #(
  parameter int ADDR_W  = 8,
  parameter int MADDR_W = 7,
  parameter int MEM_DW  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_cyc,
  input logic               bus_stb,
  input logic               bus_ack,
  input logic               mem_cmd_valid,
  input logic               mem_cmd_ready,
  input logic [MADDR_W-1:0] mem_cmd_addr,
  input logic               mem_cmd_we,
  input logic               mem_wr_valid,
  input logic               mem_wr_ready,
  input logic [MEM_DW-1:0]  mem_wr_data,
  input logic               mem_rd_ready
);
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bus_ack && !mem_cmd_valid && !mem_wr_valid && !mem_rd_ready)); // R1
  AST_RD_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd_ready) |-> $past(mem_cmd_valid && mem_cmd_ready && !mem_cmd_we)); // R3
  AST_WB_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr_valid) |-> $past(mem_cmd_valid && mem_cmd_ready && mem_cmd_we)); // R6
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
    $countones({mem_cmd_valid, mem_wr_valid, mem_rd_ready}) <= 1); // R8
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_cmd_valid && !mem_cmd_ready) |=>
      (mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_we))); // R8
  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_data))); // R8
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack); // R9
  AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> $past(bus_cyc && bus_stb)); // R9
endmodule

bind wb_cache wb_cache_chk #(
  .ADDR_W (ADDR_W),
  .MADDR_W(MADDR_W),
  .MEM_DW (MEM_DW)
) i_chk (
  .clk           (clk),
  .rst           (rst),
  .bus_cyc       (bus_cyc),
  .bus_stb       (bus_stb),
  .bus_ack       (bus_ack),
  .mem_cmd_valid (mem_cmd_valid),
  .mem_cmd_ready (mem_cmd_ready),
  .mem_cmd_addr  (mem_cmd_addr),
  .mem_cmd_we    (mem_cmd_we),
  .mem_wr_valid  (mem_wr_valid),
  .mem_wr_ready  (mem_wr_ready),
  .mem_wr_data   (mem_wr_data),
  .mem_rd_ready  (mem_rd_ready)
);

// File: tb/test_wb_cache.sv
`timescale 1ns/1ps
module test_wb_cache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_cyc = 1'b0, bus_stb = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_adr = '0;
  logic [1:0]  bus_sel = '0;
  logic [15:0] bus_dat_w = '0;
  logic [15:0] bus_dat_r;
  logic        bus_ack;
  logic        mem_cmd_valid, mem_cmd_we, mem_wr_valid, mem_rd_ready;
  logic        mem_cmd_ready = 1'b0, mem_wr_ready = 1'b0, mem_rd_valid = 1'b0;
  logic [6:0]  mem_cmd_addr;
  logic [31:0] mem_wr_data;
  logic [31:0] mem_rd_data = '0;

  always #4 clk = ~clk;

  wb_cache i_wb_cache (
    .clk(clk), .rst(rst),
    .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we), .bus_adr(bus_adr),
    .bus_sel(bus_sel), .bus_dat_w(bus_dat_w), .bus_dat_r(bus_dat_r), .bus_ack(bus_ack),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
    .mem_cmd_addr(mem_cmd_addr), .mem_cmd_we(mem_cmd_we),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_data(mem_wr_data),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data)
  );

  int checks = 0;
  int failures = 0;
  int viol = 0;

  logic [31:0] mem [128];
  int          log_n = 0;
  logic [6:0]  log_addr [64];
  logic        log_we [64];
  logic [31:0] log_wdat [64];

  function automatic logic [31:0] init_word(input int a);
    return 32'h5A00_0000 ^ (a * 32'h0103_0507);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder: one phase at a time, delay 0..2 cycles
  initial begin
    for (int i = 0; i < 128; i++) mem[i] = init_word(i);
    forever begin
      @(negedge clk);
      if (!rst && mem_cmd_valid) begin
        repeat (log_n % 3) @(negedge clk);
        mem_cmd_ready = 1'b1;
        log_addr[log_n] = mem_cmd_addr;
        log_we[log_n]   = mem_cmd_we;
        @(negedge clk);
        mem_cmd_ready = 1'b0;
        if (log_we[log_n]) begin
          while (!mem_wr_valid) @(negedge clk);
          repeat ((log_n + 1) % 3) @(negedge clk);
          mem_wr_ready = 1'b1;
          log_wdat[log_n] = mem_wr_data;
          mem[log_addr[log_n]] = mem_wr_data;
          @(negedge clk);
          mem_wr_ready = 1'b0;
        end else begin
          while (!mem_rd_ready) @(negedge clk);
          repeat ((log_n + 2) % 3) @(negedge clk);
          mem_rd_valid = 1'b1;
          mem_rd_data  = mem[log_addr[log_n]];
          @(negedge clk);
          mem_rd_valid = 1'b0;
        end
        log_n = (log_n + 1) % 64;
      end
    end
  end

  // R8 protocol monitor, sampled mid-low-phase
  initial begin
    logic       pend_c, pend_w, pwe;
    logic [6:0] padr;
    logic [31:0] pdat;
    pend_c = 0; pend_w = 0; pwe = 0; padr = '0; pdat = '0;
    forever begin
      @(negedge clk); #2;
      if (!rst) begin
        if ((32'(mem_cmd_valid) + 32'(mem_wr_valid) + 32'(mem_rd_ready)) > 1) viol++;
        if (pend_c && (!mem_cmd_valid || mem_cmd_addr != padr || mem_cmd_we != pwe)) viol++;
        if (pend_w && (!mem_wr_valid || mem_wr_data != pdat)) viol++;
        pend_c = mem_cmd_valid && !mem_cmd_ready;
        pend_w = mem_wr_valid && !mem_wr_ready;
        padr = mem_cmd_addr; pwe = mem_cmd_we; pdat = mem_wr_data;
      end
    end
  end

  task automatic bus_access(input logic w, input logic [7:0] a, input logic [1:0] s,
                            input logic [15:0] d, output logic [15:0] q, output int base,
                            output int n);
    @(negedge clk);
    base = log_n;
    bus_cyc = 1'b1; bus_stb = 1'b1; bus_we = w; bus_adr = a; bus_sel = s; bus_dat_w = d;
    do @(negedge clk); while (!bus_ack);
    q = bus_dat_r;
    n = (log_n - base + 64) % 64;
    bus_cyc = 1'b0; bus_stb = 1'b0;
    @(negedge clk);
    chk(!bus_ack, "R9 ack single cycle", 32'(bus_ack), 32'd0);
  endtask

  logic [31:0] m8;

  task automatic t_reset;
    chk(!bus_ack && !mem_cmd_valid && !mem_wr_valid && !mem_rd_ready, "R1 quiet after reset",
        {28'd0, bus_ack, mem_cmd_valid, mem_wr_valid, mem_rd_ready}, 32'd0);
  endtask

  task automatic t_first_miss;
    logic [15:0] q; int b, n;
    bus_access(1'b0, 8'h07, 2'b00, 16'h0, q, b, n);   // tag 0, index 3, offset 1
    chk(n == 1 && !log_we[b], "R1 invalid line misses", 32'(n), 32'd1);
    chk(log_addr[b] == 7'h03, "R2 address tag0 index3", 32'(log_addr[b]), 32'h03);
    chk(q == init_word(3)[31:16], "R3 upper word", 32'(q), 32'(init_word(3)[31:16]));
  endtask

  task automatic t_read_miss;
    logic [15:0] q; int b, n;
    bus_access(1'b0, 8'h11, 2'b00, 16'h0, q, b, n);
    chk(n == 1 && !log_we[b], "R3 single read command", 32'(n), 32'd1);
    chk(log_addr[b] == 7'h08, "R2 memory address", 32'(log_addr[b]), 32'h08);
    chk(q == m8[31:16], "R3 offset 1 word", 32'(q), 32'(m8[31:16]));
  endtask

  task automatic t_hit;
    logic [15:0] q; int b, n;
    bus_access(1'b0, 8'h10, 2'b00, 16'h0, q, b, n);
    chk(n == 0, "R4 read hit no traffic", 32'(n), 32'd0);
    chk(q == m8[15:0], "R3 offset 0 word", 32'(q), 32'(m8[15:0]));
  endtask

  task automatic t_lanes;
    logic [15:0] q; int b, n;
    bus_access(1'b1, 8'h10, 2'b01, 16'hBEEF, q, b, n);
    chk(n == 0, "R4 write hit no traffic", 32'(n), 32'd0);
    bus_access(1'b0, 8'h10, 2'b00, 16'h0, q, b, n);
    chk(q == {m8[15:8], 8'hEF}, "R5 low lane only", 32'(q), 32'({m8[15:8], 8'hEF}));
    bus_access(1'b1, 8'h11, 2'b10, 16'h1234, q, b, n);
    bus_access(1'b0, 8'h11, 2'b00, 16'h0, q, b, n);
    chk(q == {8'h12, m8[23:16]}, "R5 high lane only", 32'(q), 32'({8'h12, m8[23:16]}));
    bus_access(1'b1, 8'h10, 2'b00, 16'h5555, q, b, n);
    bus_access(1'b0, 8'h10, 2'b00, 16'h0, q, b, n);
    chk(q == {m8[15:8], 8'hEF}, "R5 empty select", 32'(q), 32'({m8[15:8], 8'hEF}));
  endtask

  task automatic t_dirty_evict;
    logic [15:0] q; int b, n;
    logic [31:0] exp_line;
    exp_line = {8'h12, m8[23:16], m8[15:8], 8'hEF};
    bus_access(1'b0, 8'h18, 2'b00, 16'h0, q, b, n);
    chk(n == 2, "R6 two commands", 32'(n), 32'd2);
    chk(log_we[b] && log_addr[b] == 7'h08, "R6 write-back first at victim",
        {24'd0, log_we[b], log_addr[b]}, {24'd0, 1'b1, 7'h08});
    chk(log_wdat[b] == exp_line, "R6 latest line data", log_wdat[b], exp_line);
    chk(!log_we[(b+1)%64] && log_addr[(b+1)%64] == 7'h0C, "R6 then read new line",
        {24'd0, log_we[(b+1)%64], log_addr[(b+1)%64]}, {24'd0, 1'b0, 7'h0C});
    chk(q == init_word(12)[15:0], "R3 new line word", 32'(q), 32'(init_word(12)[15:0]));
  endtask

  task automatic t_clean_evict;
    logic [15:0] q; int b, n;
    bus_access(1'b0, 8'h10, 2'b00, 16'h0, q, b, n);
    chk(n == 1 && !log_we[b], "R7 no write-back", 32'(n), 32'd1);
    chk(q == {m8[15:8], 8'hEF}, "R9 data restored from memory", 32'(q), 32'({m8[15:8], 8'hEF}));
  endtask

  task automatic t_write_miss;
    logic [15:0] q; int b, n;
    logic [31:0] m11, exp_line;
    m11 = init_word(17);
    exp_line = {16'hCAFE, m11[15:0]};
    bus_access(1'b1, 8'h23, 2'b11, 16'hCAFE, q, b, n);
    chk(n == 1 && !log_we[b] && log_addr[b] == 7'h11, "R9 write miss refills first",
        32'(log_addr[b]), 32'h11);
    bus_access(1'b0, 8'h23, 2'b00, 16'h0, q, b, n);
    chk(q == 16'hCAFE && n == 0, "R9 read after write", 32'(q), 32'hCAFE);
    bus_access(1'b0, 8'h2B, 2'b00, 16'h0, q, b, n);
    chk(n == 2 && log_we[b] && log_addr[b] == 7'h11, "R6 evict index1",
        32'(log_addr[b]), 32'h11);
    chk(log_wdat[b] == exp_line, "R6 merged line written", log_wdat[b], exp_line);
    chk(q == init_word(21)[31:16], "R2 tag5 index1 fetch", 32'(q), 32'(init_word(21)[31:16]));
  endtask

  initial begin
    m8 = init_word(8);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_first_miss();
    t_read_miss();
    t_hit();
    t_lanes();
    t_dirty_evict();
    t_clean_evict();
    t_write_miss();
    repeat (4) @(negedge clk);
    chk(viol == 0, "R8 one phase and held valid", 32'(viol), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule